// File: doc/BRIEF.md
# RTC Supervisory Interrupt Unit

This block is the supervisory part of a real-time clock. It holds a watchdog down-counter advanced by a 32 Hz strobe, a four-field BCD alarm comparator with a per-field ignore bit, and an interrupt combiner that drives a single interrupt pin. The calendar counters live elsewhere. They present the current seconds, minutes, hours and date in BCD, together with a once-per-second strobe. A power-fail level and an on-backup level come from the supply monitor.

Software reaches the block through a byte-wide register port with a 3-bit address. The register addresses are: 0 event flags, 1 alarm seconds, 2 alarm minutes, 3 alarm hours, 4 alarm date, 5 interrupt control, 6 watchdog. Read data is combinational on the address. Side effects of a read, such as clearing the flags, take place at the clock edge that ends the read cycle.

Top module: `rtcsup_top`

## Requirements
- R1: After reset the flags read 0x00, interrupt control reads 0x24 and the watchdog register reads 0x40 (locked, timeout 0). With active-high polarity the pin is driven inactive: int_oe=1 and int_out=0.
- R2: The watchdog register is {strobe, lock, timeout[5:0]}. Every write stores bit 6 as the new lock. The timeout is replaced only when the lock stored by an earlier write is 0. Bit 7 always reads 0.
- R3: A strobe write, or a write that changes the timeout, reloads the counter at the next 32 Hz strobe. With timeout N > 0, the watchdog flag (flags bit 7) sets on the N-th strobe after that reload. A timeout of 0 never sets the flag.
- R4: A strobe written before the count runs out restarts the full interval, so no flag is raised at the old deadline.
- R5: Each alarm register is {ignore, value[6:0]}. A field with ignore=0 must equal its time input. When a seconds strobe arrives and all fields match, the alarm flag (flags bit 6) sets. If all four ignore bits are 1, every seconds strobe sets the flag.
- R6: The alarm flag never sets in a cycle without a seconds strobe, even while the time matches.
- R7: The power-fail flag (flags bit 5) sets on a rising edge of pwr_fail only. A level that stays high does not set it again after it is cleared.
- R8: A read of address 0 returns {wd, alarm, pf, 00000} and clears all three flags. A flag event in the same cycle as the read wins.
- R9: Interrupt control bits: 7 watchdog enable, 6 alarm enable, 5 power-fail enable, 4 alarm-in-backup enable, 3 pulse mode, 2 active-high polarity. In level mode (bit 3 = 0) the interrupt is active while any enabled flag is set, and goes inactive after the flags are read.
- R10: In pulse mode (bit 3 = 1) a new interrupt condition makes the pin active for PULSE_TICKS (default 7) 32 Hz strobes. Reading the flags ends the pulse at once.
- R11: With polarity low the pin is open-drain active-low: int_out=0 and int_oe equals the active state. With polarity high the pin is push-pull (int_oe=1, int_out=active), but while on_backup=1 it is released (int_oe=0, int_out=0). During backup the alarm flag reaches the interrupt only when bit 4 is set.
- R12: A flag whose enable bit is 0 still sets and reads back, but it does not activate the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick32 | input | 1 | One-cycle strobe at 32 Hz |
| tick1s | input | 1 | One-cycle strobe once per second |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours, BCD, 24-hour |
| now_date | input | 7 | Current day of month, BCD |
| pwr_fail | input | 1 | Supply-fail level from the monitor |
| on_backup | input | 1 | High while running from the backup source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| int_out | output | 1 | Interrupt pin drive value |
| int_oe | output | 1 | Interrupt pin output enable |

## Verification
The alarm comparator is tested with an exact seconds match and a seconds value one off. It is also tested with a minutes field one off while the seconds field matches, and with every field ignored. Together these show whether each field is compared, whether the ignore bit works, and whether the strobe is needed at all. The watchdog is run through an uninterrupted countdown, a countdown refreshed halfway, and a zero timeout. These separate an off-by-one in the reload tick from a missing restart. The pin is checked in both polarities, in both output modes and with backup on and off. This shows whether gating, pulse length and release are each applied.

// File: rtl/rtcsup_pkg.sv
`timescale 1ns/1ps
// rtcsup_pkg: register addresses, control-bit positions and shared types
// for the RTC supervisory unit. Assumes a 3-bit register address.
package rtcsup_pkg;
    localparam int ADDR_W       = 3;
    localparam int BCD_W        = 7;
    localparam int ALARM_FIELDS = 4;
    localparam int AIDX_W       = $clog2(ALARM_FIELDS);
    localparam int TMO_W        = 6;

    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd0;
    localparam logic [ADDR_W-1:0] A_AL_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_AL_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_IRQ   = 3'd5;
    localparam logic [ADDR_W-1:0] A_WDOG  = 3'd6;

    // interrupt control bit positions
    localparam int CB_WD_EN  = 7;
    localparam int CB_AL_EN  = 6;
    localparam int CB_PF_EN  = 5;
    localparam int CB_AL_BAK = 4;
    localparam int CB_PULSE  = 3;
    localparam int CB_POL_HI = 2;
    localparam logic [7:0] IRQ_RESET = 8'h24;

    // flag vector index (flags register bits 7..5)
    localparam int FI_WD = 2;
    localparam int FI_AL = 1;
    localparam int FI_PF = 0;

    typedef struct packed {
        logic             ignore;
        logic [BCD_W-1:0] value;
    } alarm_field_t;
endpackage

// File: rtl/rtcsup_watchdog.sv
`timescale 1ns/1ps
// rtcsup_watchdog: 6-bit down-counter advanced by the 32 Hz strobe.
// The timeout field is write-protected by the lock bit stored on an
// earlier write. A strobe or new timeout reloads at the next tick.
// Assumes tick32 is a single-cycle pulse.
module rtcsup_watchdog
    import rtcsup_pkg::*;
#(
    parameter logic [TMO_W-1:0] RESET_TMO = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    input  logic             tick32,
    output logic [TMO_W-1:0] tmo_q,
    output logic             lock_q,
    output logic             expire
);
    logic [TMO_W-1:0] cnt_q;
    logic             reload_q;
    logic             strobe;

    assign strobe = wdata[7];
    assign expire = tick32 && !reload_q && (tmo_q != '0) && (cnt_q == TMO_W'(1));

    // register writes: lock always, timeout only when unlocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q  <= RESET_TMO;
            lock_q <= 1'b1;
        end else if (wr_en) begin
            lock_q <= wdata[6];
            if (!lock_q) tmo_q <= wdata[TMO_W-1:0];
        end
    end

    // pending reload request, consumed at the next tick
    always_ff @(posedge clk) begin
        if (!rst_n)                               reload_q <= 1'b0;
        else if (wr_en && (strobe || !lock_q))    reload_q <= 1'b1;
        else if (tick32)                          reload_q <= 1'b0;
    end

    // the down-counter itself
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RESET_TMO;
        end else if (tick32) begin
            if (reload_q)           cnt_q <= tmo_q;
            else if (tmo_q == '0)   cnt_q <= '0;
            else if (cnt_q != '0)   cnt_q <= cnt_q - TMO_W'(1);
        end
    end
endmodule

// File: rtl/rtcsup_alarm.sv
`timescale 1ns/1ps
// rtcsup_alarm: BCD alarm registers with an ignore bit per field and a
// comparator evaluated only on the seconds strobe, so each match raises
// one event. Field 0 is seconds, then minutes, hours, date.
module rtcsup_alarm
    import rtcsup_pkg::*;
#(
    parameter int N = ALARM_FIELDS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AIDX_W-1:0]          wr_idx,
    input  logic [7:0]                 wdata,
    input  logic                       tick1s,
    input  logic [N-1:0][BCD_W-1:0]    now_bcd,
    output alarm_field_t [N-1:0]       fields_q,
    output logic                       hit
);
    logic [N-1:0] field_ok;

    for (genvar i = 0; i < N; i++) begin : g_field
        // one alarm field register
        always_ff @(posedge clk) begin
            if (!rst_n)                                  fields_q[i] <= '0;
            else if (wr_en && (wr_idx == AIDX_W'(i)))    fields_q[i] <= wdata;
        end
        assign field_ok[i] = fields_q[i].ignore || (fields_q[i].value == now_bcd[i]);
    end

    assign hit = tick1s && (&field_ok);
endmodule

// File: rtl/rtcsup_irq.sv
`timescale 1ns/1ps
// rtcsup_irq: event flags, interrupt control register, pulse timer and
// pin driver. Flags clear on a flags read; a same-cycle event wins.
// The pulse length is counted in 32 Hz strobes.
module rtcsup_irq
    import rtcsup_pkg::*;
#(
    parameter int PULSE_TICKS = 7,
    localparam int PW = $clog2(PULSE_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [7:2] wdata,
    input  logic       flags_rd,
    input  logic       wd_exp,
    input  logic       al_hit,
    input  logic       pwr_fail,
    input  logic       on_backup,
    input  logic       tick32,
    output logic [7:2] ctrl_q,
    output logic [2:0] flags_q,
    output logic       pf_rise,
    output logic       int_out,
    output logic       int_oe
);
    logic          pf_prev_q;
    logic          cond, cond_q, trigger, active;
    logic [PW-1:0] pulse_q;

    assign pf_rise = pwr_fail && !pf_prev_q;

    // interrupt control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= IRQ_RESET[7:2];
        else if (ctrl_wr) ctrl_q <= wdata;
    end

    // power-fail edge detector
    always_ff @(posedge clk) begin
        if (!rst_n) pf_prev_q <= 1'b0;
        else        pf_prev_q <= pwr_fail;
    end

    // sticky event flags, cleared by a flags read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q[FI_WD] <= wd_exp  || (flags_q[FI_WD] && !flags_rd);
            flags_q[FI_AL] <= al_hit  || (flags_q[FI_AL] && !flags_rd);
            flags_q[FI_PF] <= pf_rise || (flags_q[FI_PF] && !flags_rd);
        end
    end

    assign cond = (ctrl_q[CB_WD_EN] && flags_q[FI_WD])
               || (ctrl_q[CB_AL_EN] && flags_q[FI_AL] && (!on_backup || ctrl_q[CB_AL_BAK]))
               || (ctrl_q[CB_PF_EN] && flags_q[FI_PF]);
    assign trigger = cond && !cond_q;

    // condition history for pulse triggering
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond;
    end

    // pulse-mode timer
    always_ff @(posedge clk) begin
        if (!rst_n)                       pulse_q <= '0;
        else if (flags_rd)                pulse_q <= '0;
        else if (trigger)                 pulse_q <= PW'(PULSE_TICKS);
        else if (tick32 && pulse_q != '0) pulse_q <= pulse_q - PW'(1);
    end

    assign active = ctrl_q[CB_PULSE] ? (pulse_q != '0) : cond;

    // pin driver: push-pull active-high or open-drain active-low
    always_comb begin
        if (ctrl_q[CB_POL_HI]) begin
            int_oe  = !on_backup;
            int_out = active && !on_backup;
        end else begin
            int_oe  = active;
            int_out = 1'b0;
        end
    end
endmodule

// File: rtl/rtcsup_top.sv
`timescale 1ns/1ps
// rtcsup_top: RTC supervisory unit. Decodes the byte register port and
// connects watchdog, alarm comparator and interrupt combiner. Read data
// is combinational; read side effects occur at the closing edge.
module rtcsup_top
    import rtcsup_pkg::*;
#(
    parameter int                PULSE_TICKS = 7,
    parameter logic [TMO_W-1:0]  WD_RESET_TMO = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick32,
    input  logic              tick1s,
    input  logic [BCD_W-1:0]  now_sec,
    input  logic [BCD_W-1:0]  now_min,
    input  logic [BCD_W-1:0]  now_hour,
    input  logic [BCD_W-1:0]  now_date,
    input  logic              pwr_fail,
    input  logic              on_backup,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              int_out,
    output logic              int_oe
);
    logic [TMO_W-1:0]                    wd_tmo;
    logic                                wd_lock, wd_exp, al_hit, pf_rise;
    logic                                al_sel;
    logic [AIDX_W-1:0]                   al_idx;
    alarm_field_t [ALARM_FIELDS-1:0]     al_fields;
    logic [7:2]                          ctrl_q;
    logic [2:0]                          irq_flags;

    assign al_sel = (reg_addr >= A_AL_LO) && (reg_addr <= A_AL_HI);
    assign al_idx = AIDX_W'(reg_addr - A_AL_LO);

    rtcsup_watchdog #(.RESET_TMO(WD_RESET_TMO)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr && reg_addr == A_WDOG),
        .wdata  (reg_wdata),
        .tick32 (tick32),
        .tmo_q  (wd_tmo),
        .lock_q (wd_lock),
        .expire (wd_exp)
    );

    rtcsup_alarm #(.N(ALARM_FIELDS)) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr && al_sel),
        .wr_idx   (al_idx),
        .wdata    (reg_wdata),
        .tick1s   (tick1s),
        .now_bcd  ({now_date, now_hour, now_min, now_sec}),
        .fields_q (al_fields),
        .hit      (al_hit)
    );

    rtcsup_irq #(.PULSE_TICKS(PULSE_TICKS)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (reg_wr && reg_addr == A_IRQ),
        .wdata     (reg_wdata[7:2]),
        .flags_rd  (reg_rd && reg_addr == A_FLAGS),
        .wd_exp    (wd_exp),
        .al_hit    (al_hit),
        .pwr_fail  (pwr_fail),
        .on_backup (on_backup),
        .tick32    (tick32),
        .ctrl_q    (ctrl_q),
        .flags_q   (irq_flags),
        .pf_rise   (pf_rise),
        .int_out   (int_out),
        .int_oe    (int_oe)
    );

    // read-back multiplexer
    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == A_FLAGS)     reg_rdata = {irq_flags, 5'b0};
        else if (al_sel)             reg_rdata = al_fields[al_idx];
        else if (reg_addr == A_IRQ)  reg_rdata = {ctrl_q, 2'b00};
        else if (reg_addr == A_WDOG) reg_rdata = {1'b0, wd_lock, wd_tmo};
    end
endmodule

// File: rtl/rtcsup_checker.sv
`timescale 1ns/1ps
// rtcsup_checker: temporal properties of the supervisory unit, bound
// into rtcsup_top.
module rtcsup_checker
    import rtcsup_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick1s,
    input logic              pwr_fail,
    input logic              on_backup,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              int_out,
    input logic              int_oe,
    input logic [7:2]        ctrl,
    input logic [2:0]        flags,
    input logic              wd_exp,
    input logic              al_hit,
    input logic              pf_rise,
    input logic [TMO_W-1:0]  wd_tmo,
    input logic              wd_lock
);
    p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_WDOG && wd_lock) |=> $stable(wd_tmo));

    p_zero_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_tmo == '0) |-> !wd_exp);

    p_alarm_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FI_AL]) |-> $past(tick1s));

    p_pf_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FI_PF]) |-> $past(pwr_fail));

    p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_FLAGS && !wd_exp && !al_hit && !pf_rise) |=> (flags == 3'b000));

    p_level_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[CB_PULSE] && ctrl[CB_POL_HI] && flags == 3'b000) |-> !int_out);

    p_backup_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (on_backup && ctrl[CB_POL_HI]) |-> !int_oe);

    p_open_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[CB_POL_HI] |-> !int_out);
endmodule

bind rtcsup_top rtcsup_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick1s    (tick1s),
    .pwr_fail  (pwr_fail),
    .on_backup (on_backup),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .int_out   (int_out),
    .int_oe    (int_oe),
    .ctrl      (ctrl_q),
    .flags     (irq_flags),
    .wd_exp    (wd_exp),
    .al_hit    (al_hit),
    .pf_rise   (pf_rise),
    .wd_tmo    (wd_tmo),
    .wd_lock   (wd_lock)
);

// File: tb/rtcsup_top_test.sv
`timescale 1ns/1ps
// Directed bench for rtcsup_top: one task per scenario.
module rtcsup_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick32 = 1'b0, tick1s = 1'b0;
    logic [6:0] now_sec = 7'h00, now_min = 7'h00, now_hour = 7'h00, now_date = 7'h01;
    logic       pwr_fail = 1'b0, on_backup = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       int_out, int_oe;
    int         checks = 0;
    int         failures = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;

    rtcsup_top uut (
        .clk(clk), .rst_n(rst_n), .tick32(tick32), .tick1s(tick1s),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
        .pwr_fail(pwr_fail), .on_backup(on_backup),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .int_out(int_out), .int_oe(int_oe)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic check_pin(input string tag, input logic exp_out, input logic exp_oe);
        #1;
        check8(tag, {6'b0, int_out, int_oe}, {6'b0, exp_out, exp_oe});
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 check8(tag, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse32(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick32 = 1'b1;
            @(negedge clk); tick32 = 1'b0;
        end
    endtask

    task automatic pulse1s();
        @(negedge clk); tick1s = 1'b1;
        @(negedge clk); tick1s = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check_pin("R1 pin after reset", 1'b0, 1'b1);
        rd_check(3'd0, 8'h00, "R1 flags after reset");
        rd_check(3'd5, 8'h24, "R1 control after reset");
        rd_check(3'd6, 8'h40, "R1 watchdog after reset");
    endtask

    task automatic t_wd_lock();
        wr(3'd6, 8'h05);
        rd_check(3'd6, 8'h00, "R2 locked write keeps timeout, clears lock");
        wr(3'd6, 8'h45);
        rd_check(3'd6, 8'h45, "R2 unlocked write takes timeout");
        wr(3'd6, 8'h0A);
        rd_check(3'd6, 8'h05, "R2 relocked write ignored");
        wr(3'd6, 8'h83);
        rd_check(3'd6, 8'h03, "R2 strobe reads back zero");
    endtask

    task automatic t_wd_count();
        wr(3'd5, 8'h84);
        rd_check(3'd0, 8'h00, "R3 flags clean before countdown");
        pulse32(3);
        check_pin("R3 no expiry before deadline", 1'b0, 1'b1);
        pulse32(1);
        check_pin("R3 expiry on deadline R9 level", 1'b1, 1'b1);
        rd_check(3'd0, 8'h80, "R8 watchdog flag read");
        check_pin("R9 level drops after read", 1'b0, 1'b1);
        rd_check(3'd0, 8'h00, "R8 flags cleared");
    endtask

    task automatic t_wd_refresh();
        wr(3'd6, 8'h83);
        pulse32(2);
        wr(3'd6, 8'h83);
        pulse32(3);
        check_pin("R4 refresh avoids old deadline", 1'b0, 1'b1);
        pulse32(1);
        check_pin("R4 new deadline expires", 1'b1, 1'b1);
        rd_check(3'd0, 8'h80, "R4 watchdog flag after refresh");
        wr(3'd6, 8'h80);
        pulse32(6);
        rd_check(3'd0, 8'h00, "R3 zero timeout never fires");
    endtask

    task automatic t_alarm();
        wr(3'd5, 8'h44);
        wr(3'd1, 8'h30); wr(3'd2, 8'h80); wr(3'd3, 8'h80); wr(3'd4, 8'h80);
        now_sec = 7'h30; now_min = 7'h14; now_hour = 7'h09; now_date = 7'h21;
        pulse1s();
        check_pin("R5 seconds match raises pin", 1'b1, 1'b1);
        rd_check(3'd0, 8'h40, "R5 seconds match flag");
        now_sec = 7'h31;
        pulse1s();
        rd_check(3'd0, 8'h00, "R5 seconds mismatch");
        wr(3'd2, 8'h15);
        rd_check(3'd2, 8'h15, "R5 alarm minutes readback");
        now_sec = 7'h30;
        pulse1s();
        rd_check(3'd0, 8'h00, "R5 minutes mismatch blocks");
        now_min = 7'h15;
        pulse1s();
        rd_check(3'd0, 8'h40, "R5 two-field match");
        wr(3'd1, 8'h80); wr(3'd2, 8'h80);
        now_sec = 7'h47;
        pulse1s();
        rd_check(3'd0, 8'h40, "R5 all ignored fires every second");
        idle(6);
        rd_check(3'd0, 8'h00, "R6 no flag without seconds strobe");
    endtask

    task automatic t_powerfail();
        wr(3'd5, 8'h24);
        @(negedge clk); pwr_fail = 1'b1;
        @(negedge clk);
        check_pin("R7 power-fail edge raises pin", 1'b1, 1'b1);
        rd_check(3'd0, 8'h20, "R7 power-fail flag");
        idle(3);
        rd_check(3'd0, 8'h00, "R7 held level does not re-set");
        pwr_fail = 1'b0;
    endtask

    task automatic t_enable_gating();
        wr(3'd5, 8'h04);
        pulse1s();
        check_pin("R12 disabled alarm keeps pin idle", 1'b0, 1'b1);
        rd_check(3'd0, 8'h40, "R12 disabled alarm still flags");
    endtask

    task automatic t_pulse();
        wr(3'd5, 8'h4C);
        pulse1s();
        @(negedge clk);
        check_pin("R10 pulse starts", 1'b1, 1'b1);
        pulse32(6);
        check_pin("R10 pulse still on before length", 1'b1, 1'b1);
        pulse32(1);
        check_pin("R10 pulse ends after length", 1'b0, 1'b1);
        rd_check(3'd0, 8'h40, "R10 flag outlives pulse");
        pulse1s();
        @(negedge clk);
        check_pin("R10 second pulse starts", 1'b1, 1'b1);
        rd_check(3'd0, 8'h40, "R10 read during pulse");
        check_pin("R10 read ends pulse early", 1'b0, 1'b1);
    endtask

    task automatic t_polarity();
        wr(3'd5, 8'h40);
        pulse1s();
        check_pin("R11 open-drain active low", 1'b0, 1'b1);
        rd_check(3'd0, 8'h40, "R11 flag in open-drain mode");
        check_pin("R11 open-drain released", 1'b0, 1'b0);
        on_backup = 1'b1;
        wr(3'd5, 8'h54);
        pulse1s();
        check_pin("R11 push-pull released in backup", 1'b0, 1'b0);
        wr(3'd5, 8'h50);
        check_pin("R11 open-drain alarm in backup enabled", 1'b0, 1'b1);
        wr(3'd5, 8'h40);
        check_pin("R11 alarm blocked in backup", 1'b0, 1'b0);
        rd_check(3'd0, 8'h40, "R11 backup alarm flag");
        on_backup = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wd_lock();
        t_wd_count();
        t_wd_refresh();
        t_alarm();
        t_powerfail();
        t_enable_gating();
        t_pulse();
        t_polarity();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog timeout actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule